// File: doc/BRIEF.md
# Dual-Group Thread Issue Picker

This block chooses which hardware threads send an instruction down two execution pipes in each cycle. Eight threads are split into two fixed groups of four. Each group has its own picker. Among the threads of its group that are ready, a picker prefers threads that are not speculative. Among those it takes the one picked longest ago. Both groups can therefore issue in the same cycle, one instruction each.

Both pipes reach one load/store port and one floating-point unit. If both group choices need the same one of these shared units, a resolver lets only one through. The winner is the group that was refused at the last such clash. The refused instruction stays with its thread, so it is offered again later. A throttle input can block all issue for one cycle. The picks are registered: a choice made from the inputs present at clock edge N appears on the outputs after edge N.

Top module: `thread_pick_top`

## Requirements
- R1: Threads 0–3 form group 0 and are reported on `pick_tid0`. Threads 4–7 form group 1 and are reported on `pick_tid1` as global numbers 4–7. A thread ID output is 0 while its valid bit is low.
- R2: The outputs are registered. A pick made from the inputs sampled at a rising edge appears on the outputs immediately after that edge.
- R3: A thread can be picked only if its `inst_vld` bit is set and none of its four wait bits is set: dependency, data-cache miss, data-TLB miss or divide/square-root busy.
- R4: Within a group, the picker takes the qualifying thread that has gone longest without issuing. After reset the age order is by ascending thread number, with the lowest number oldest. A thread that issues becomes the youngest in its group.
- R5: If any ready thread in a group has its `is_spec` bit low, only the nonspeculative ready threads of that group compete. If all ready threads in the group are speculative, they all compete.
- R6: The two groups pick independently, so both `pick_vld` bits can be set in the same cycle.
- R7: If both group choices have `is_ldst` set, only one of them issues. The group refused at the previous clash wins. After reset, group 0 wins the first clash.
- R8: The rule of R7 also applies when both choices have `is_fp` set. One choice with `is_ldst` set and the other with `is_fp` set is not a clash.
- R9: A group refused in a clash issues nothing in that cycle, and its age order does not change.
- R10: While `throttle` is high, neither group issues. Neither age order changes, and the clash winner state does not change.
- R11: While `rst` is high, both `pick_vld` bits and both thread ID outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| throttle | input | 1 | Block all issue this cycle |
| inst_vld | input | 8 | Thread has an instruction available |
| wait_dep | input | 8 | Thread waits on an operand dependency |
| wait_dmiss | input | 8 | Thread waits on a data-cache miss |
| wait_tlb | input | 8 | Thread waits on a data-TLB miss |
| wait_div | input | 8 | Thread waits on divide/square-root |
| is_spec | input | 8 | Thread's instruction is speculative |
| is_ldst | input | 8 | Thread's instruction uses the load/store port |
| is_fp | input | 8 | Thread's instruction uses the floating-point unit |
| pick_vld | output | 2 | Per-group issue valid (bit g = group g) |
| pick_tid0 | output | 3 | Global ID of group 0's issued thread |
| pick_tid1 | output | 3 | Global ID of group 1's issued thread |

## Verification
Each group's age-ordered pick and the cross-group resolver act in the same cycle. A clash therefore changes which group's age order moves, and how that order moves. The bench keeps every thread's load/store bit high across several cycles in a row, and then repeats this with the floating-point bit. It then checks that the winning group alternates from cycle to cycle. It also checks that the refused group's next pick is the same thread that was refused. A throttled clash cycle is followed by an unthrottled one, to show that neither the winner state nor either age order moved.

// File: rtl/thread_pick_pkg.sv
package thread_pick_pkg;
  localparam int NUM_GROUPS = 2;

  typedef struct packed {
    logic ldst;
    logic fp;
  } pick_cls_t;
endpackage

// File: rtl/tp_ready_mask.sv
module tp_ready_mask #(
  parameter int GROUP_SIZE = 4,
  parameter int NUM_GROUPS = 2,
  localparam int NT = GROUP_SIZE * NUM_GROUPS
) (
  input  logic [NT-1:0] inst_vld,
  input  logic [NT-1:0] wait_dep,
  input  logic [NT-1:0] wait_dmiss,
  input  logic [NT-1:0] wait_tlb,
  input  logic [NT-1:0] wait_div,
  input  logic [NT-1:0] is_spec,
  output logic [NT-1:0] cand
);
  logic [NT-1:0] ready;

  assign ready = inst_vld & ~(wait_dep | wait_dmiss | wait_tlb | wait_div);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [GROUP_SIZE-1:0] rdy_g;
    logic [GROUP_SIZE-1:0] nonspec_g;

    assign rdy_g     = ready[g*GROUP_SIZE +: GROUP_SIZE];
    assign nonspec_g = rdy_g & ~is_spec[g*GROUP_SIZE +: GROUP_SIZE];
    // speculative threads compete only when no nonspeculative one is ready
    assign cand[g*GROUP_SIZE +: GROUP_SIZE] = (|nonspec_g) ? nonspec_g : rdy_g;
  end
endmodule

// File: rtl/tp_group_lru.sv
module tp_group_lru #(
  parameter int GROUP_SIZE = 4,
  localparam int LW = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [GROUP_SIZE-1:0] cand,
  input  logic                  issue,
  output logic                  req,
  output logic [LW-1:0]         sel
);
  // ord_q[0] is the thread picked longest ago
  logic [LW-1:0] ord_q [GROUP_SIZE];
  logic [LW-1:0] ord_d [GROUP_SIZE];
  logic [LW-1:0] pos;

  always_comb begin
    req = 1'b0;
    pos = '0;
    sel = '0;
    for (int i = GROUP_SIZE - 1; i >= 0; i--) begin
      if (cand[ord_q[i]]) begin
        req = 1'b1;
        pos = LW'(i);
        sel = ord_q[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < GROUP_SIZE - 1; i++) begin
      ord_d[i] = (i >= int'(pos)) ? ord_q[i+1] : ord_q[i];
    end
    ord_d[GROUP_SIZE-1] = sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < GROUP_SIZE; i++) ord_q[i] <= LW'(i);
    end else if (issue) begin
      for (int i = 0; i < GROUP_SIZE; i++) ord_q[i] <= ord_d[i];
    end
  end

  // R3: an issue grant only ever lands on a qualifying thread
  p_issue_ready_r3: assert property (@(posedge clk) disable iff (rst)
    issue |-> (req && cand[sel]));

  // R4: the youngest slot holds the thread that just issued
  p_youngest_r4: assert property (@(posedge clk) disable iff (rst)
    issue |=> (ord_q[GROUP_SIZE-1] == $past(sel)));
endmodule

// File: rtl/tp_conflict.sv
module tp_conflict
  import thread_pick_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       throttle,
  input  logic      [NUM_GROUPS-1:0] req,
  input  pick_cls_t [NUM_GROUPS-1:0] cls,
  output logic      [NUM_GROUPS-1:0] grant
);
  // index of the group refused at the last clash; it wins the next one
  logic loser_q;
  logic clash;

  assign clash = req[0] && req[1] &&
                 ((cls[0].ldst && cls[1].ldst) || (cls[0].fp && cls[1].fp));

  always_comb begin
    grant = '0;
    if (!throttle) begin
      if (clash) grant[loser_q] = 1'b1;
      else       grant = req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     loser_q <= 1'b0;
    else if (clash && !throttle) loser_q <= ~loser_q;
  end

  // R7: never two load/store issues together
  p_no_dual_ldst_r7: assert property (@(posedge clk) disable iff (rst)
    (&grant) |-> !(cls[0].ldst && cls[1].ldst));

  // R8: never two floating-point issues together
  p_no_dual_fp_r8: assert property (@(posedge clk) disable iff (rst)
    (&grant) |-> !(cls[0].fp && cls[1].fp));

  // R7: an unthrottled clash grants exactly one group
  p_one_winner_r7: assert property (@(posedge clk) disable iff (rst)
    (clash && !throttle) |-> $onehot(grant));

  // R7: consecutive unthrottled clashes alternate the winner
  p_alternate_r7: assert property (@(posedge clk) disable iff (rst)
    (clash && !throttle) |=> (clash && !throttle) |-> (grant != $past(grant)));
endmodule

// File: rtl/thread_pick_top.sv
module thread_pick_top
  import thread_pick_pkg::*;
#(
  parameter int GROUP_SIZE = 4,
  localparam int NT = GROUP_SIZE * NUM_GROUPS,
  localparam int TW = $clog2(NT),
  localparam int LW = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  throttle,
  input  logic [NT-1:0]         inst_vld,
  input  logic [NT-1:0]         wait_dep,
  input  logic [NT-1:0]         wait_dmiss,
  input  logic [NT-1:0]         wait_tlb,
  input  logic [NT-1:0]         wait_div,
  input  logic [NT-1:0]         is_spec,
  input  logic [NT-1:0]         is_ldst,
  input  logic [NT-1:0]         is_fp,
  output logic [NUM_GROUPS-1:0] pick_vld,
  output logic [TW-1:0]         pick_tid0,
  output logic [TW-1:0]         pick_tid1
);
  logic      [NT-1:0]         cand;
  logic      [NUM_GROUPS-1:0] req;
  logic      [NUM_GROUPS-1:0] grant;
  pick_cls_t [NUM_GROUPS-1:0] cls;
  logic      [TW-1:0]         gtid [NUM_GROUPS];
  logic      [TW-1:0]         tid_q [NUM_GROUPS];
  logic      [NUM_GROUPS-1:0] vld_q;

  tp_ready_mask #(.GROUP_SIZE(GROUP_SIZE), .NUM_GROUPS(NUM_GROUPS)) u_mask (
    .inst_vld  (inst_vld),
    .wait_dep  (wait_dep),
    .wait_dmiss(wait_dmiss),
    .wait_tlb  (wait_tlb),
    .wait_div  (wait_div),
    .is_spec   (is_spec),
    .cand      (cand)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pick
    logic [LW-1:0] sel;

    tp_group_lru #(.GROUP_SIZE(GROUP_SIZE)) u_lru (
      .clk  (clk),
      .rst  (rst),
      .cand (cand[g*GROUP_SIZE +: GROUP_SIZE]),
      .issue(grant[g]),
      .req  (req[g]),
      .sel  (sel)
    );

    assign gtid[g]     = TW'(g * GROUP_SIZE) + TW'(sel);
    assign cls[g].ldst = is_ldst[gtid[g]];
    assign cls[g].fp   = is_fp[gtid[g]];

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
        tid_q[g] <= '0;
      end else begin
        vld_q[g] <= grant[g];
        tid_q[g] <= grant[g] ? gtid[g] : '0;
      end
    end
  end

  tp_conflict u_conf (
    .clk     (clk),
    .rst     (rst),
    .throttle(throttle),
    .req     (req),
    .cls     (cls),
    .grant   (grant)
  );

  assign pick_vld  = vld_q;
  assign pick_tid0 = tid_q[0];
  assign pick_tid1 = tid_q[1];

  // R10: a throttled cycle leaves no pick behind
  p_throttle_r10: assert property (@(posedge clk) disable iff (rst)
    throttle |=> (pick_vld == '0));

  // R1: group 1 only reports its own threads
  p_grp1_range_r1: assert property (@(posedge clk) disable iff (rst)
    pick_vld[1] |-> (pick_tid1 >= TW'(GROUP_SIZE)));

  // R1: group 0 only reports its own threads
  p_grp0_range_r1: assert property (@(posedge clk) disable iff (rst)
    pick_vld[0] |-> (pick_tid0 < TW'(GROUP_SIZE)));
endmodule

// File: tb/thread_pick_top_test.sv
`timescale 1ns/1ps
module thread_pick_top_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       throttle;
  logic [7:0] inst_vld, wait_dep, wait_dmiss, wait_tlb, wait_div;
  logic [7:0] is_spec, is_ldst, is_fp;
  logic [1:0] pick_vld;
  logic [2:0] pick_tid0, pick_tid1;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  thread_pick_top uut (
    .clk(clk), .rst(rst), .throttle(throttle),
    .inst_vld(inst_vld), .wait_dep(wait_dep), .wait_dmiss(wait_dmiss),
    .wait_tlb(wait_tlb), .wait_div(wait_div), .is_spec(is_spec),
    .is_ldst(is_ldst), .is_fp(is_fp),
    .pick_vld(pick_vld), .pick_tid0(pick_tid0), .pick_tid1(pick_tid1)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [7:0] vld, wdep, spec, ldst, fp;
    logic       thr;
    logic [1:0] ev;
    logic [2:0] e0, e1;
  } row_t;

  // state after reset: group 0 order 0,1,2,3 ; group 1 order 4,5,6,7 ; group 0 wins first clash
  localparam int NROWS = 16;
  localparam row_t TBL [NROWS] = '{
    '{4'd2,  8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 2'b11, 3'd0, 3'd4}, // R2 first picks
    '{4'd6,  8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 2'b11, 3'd1, 3'd5}, // R6 both groups
    '{4'd3,  8'hFF, 8'h44, 8'h00, 8'h00, 8'h00, 1'b0, 2'b11, 3'd3, 3'd7}, // R3 2,6 waiting
    '{4'd1,  8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 2'b01, 3'd2, 3'd0}, // R1 only group 0
    '{4'd5,  8'hFF, 8'h00, 8'h73, 8'h00, 8'h00, 1'b0, 2'b11, 3'd3, 3'd7}, // R5 nonspec first
    '{4'd5,  8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 2'b11, 3'd0, 3'd6}, // R5 all spec
    '{4'd7,  8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 2'b01, 3'd1, 3'd0}, // R7 g0 wins
    '{4'd7,  8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 2'b10, 3'd0, 3'd4}, // R7 g1 wins
    '{4'd9,  8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 2'b01, 3'd2, 3'd0}, // R9 loser retried
    '{4'd8,  8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0, 2'b10, 3'd0, 3'd5}, // R8 fp clash
    '{4'd8,  8'hFF, 8'h00, 8'h00, 8'h0F, 8'hF0, 1'b0, 2'b11, 3'd3, 3'd7}, // R8 mixed no clash
    '{4'd10, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 2'b00, 3'd0, 3'd0}, // R10 throttle
    '{4'd4,  8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 2'b11, 3'd0, 3'd6}, // R4 order kept
    '{4'd1,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 2'b00, 3'd0, 3'd0}, // R1 ids zero
    '{4'd10, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b1, 2'b00, 3'd0, 3'd0}, // R10 clash throttled
    '{4'd10, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 2'b01, 3'd1, 3'd0}  // R10 winner unchanged
  };

  task automatic drive(input logic [7:0] v, input logic [7:0] wd, input logic [7:0] sp,
                       input logic [7:0] ls, input logic [7:0] f, input logic t);
    inst_vld = v; wait_dep = wd; is_spec = sp; is_ldst = ls; is_fp = f; throttle = t;
  endtask

  task automatic check(input int rq, input logic [1:0] ev, input logic [2:0] e0,
                       input logic [2:0] e1);
    checks++;
    if (pick_vld !== ev || pick_tid0 !== e0 || pick_tid1 !== e1) begin
      failures++;
      $display("FAIL R%0d: got vld=%b tid0=%0d tid1=%0d, expected vld=%b tid0=%0d tid1=%0d",
               rq, pick_vld, pick_tid0, pick_tid1, ev, e0, e1);
    end
  endtask

  initial begin
    rst = 1'b1;
    drive(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    wait_dmiss = '0; wait_tlb = '0; wait_div = '0;
    repeat (3) @(negedge clk);
    check(11, 2'b00, 3'd0, 3'd0);            // R11 reset state
    rst = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].vld, TBL[i].wdep, TBL[i].spec, TBL[i].ldst, TBL[i].fp, TBL[i].thr);
      @(negedge clk);
      check(int'(TBL[i].req), TBL[i].ev, TBL[i].e0, TBL[i].e1);
    end

    // R11: reset while threads are ready clears the outputs
    drive(8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check(11, 2'b00, 3'd0, 3'd0);
    rst = 1'b0;

    // R3: cache miss on thread 0, TLB miss on thread 4
    wait_dmiss = 8'h01; wait_tlb = 8'h10;
    @(negedge clk);
    check(3, 2'b11, 3'd1, 3'd5);

    // R3: divide busy on threads 0 and 4 (orders now 0,2,3,1 and 4,6,7,5)
    wait_dmiss = 8'h00; wait_tlb = 8'h00; wait_div = 8'h11;
    @(negedge clk);
    check(3, 2'b11, 3'd2, 3'd6);

    // R3: every thread waiting on a dependency
    wait_div = 8'h00; wait_dep = 8'hFF;
    @(negedge clk);
    check(3, 2'b00, 3'd0, 3'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule